// File: doc/BRIEF.md
# Interruption Priority and Status-Word Swap Unit

This block sits beside an instruction sequencer and decides which pending interruption is taken next. It watches five sources: machine check, program exception, supervisor call, external event and I/O completion. It gates them with the mask fields of the current 64-bit status word, picks the most urgent one that is enabled, and runs a swap. The swap writes the current status word, with the interruption code and instruction length code folded in, to the class's fixed low-storage save slot. It then reads the replacement status word from the class's fixed load slot and hands it to the sequencer with a one-cycle load strobe.

Machine-check, external and I/O sources hold a level request until the unit returns a one-cycle acknowledge. Program and supervisor-call events are single-cycle pulses that the unit latches until it services them. Memory is reached through a simple request/acknowledge port that carries one doubleword per transfer.

Status-word bits are numbered from the most significant end: bit b sits at vector index 63-b.

Top module: `intr_swap_unit`

## Requirements
- R1: After reset the unit is idle: busy, mem_req, psw_load, svc_pgm_clash and all three acknowledges are 0 and intr_class is 0.
- R2: Service order is machine check, then program, then supervisor call, then external, then I/O; intr_class encodes them as 1, 2, 3, 4 and 5.
- R3: The save/load slots in hex are: machine check 30/70, program 28/68, supervisor call 20/60, external 18/58, I/O 38/78.
- R4: A swap writes the save slot with mem_we=1 and waits for mem_ack. It then reads the load slot with mem_we=0 and waits for mem_ack. Next comes one cycle with psw_load=1 and psw_new equal to the data read. No other selection starts before that load cycle ends.
- R5: An I/O request on channel c<6 is enabled by status bit c (index 63-c); channels 6 and above share bit 6 (index 57). An external request is enabled by bit 7 (index 56). A disabled request is neither acknowledged nor swapped while it stays disabled.
- R6: Program codes 8, 10, 13 and 14 are enabled by status bits 36, 37, 38 and 39 (indices 27..24). Such a pulse arriving while its bit is 0 is discarded. Other codes are always taken.
- R7: The saved word equals the current status word, except that bits 16-31 (indices 47..32) take the interruption code and bits 32-33 (indices 31..30) take the length code. The code is {channel, device} for I/O, {8'h00, source bits} for external, {8'h00, call number} for supervisor call and the zero-extended exception code for program. Only supervisor call and program replace the length code. A machine check saves the word unchanged.
- R8: A program pulse flagged imprecise saves a length code of 0.
- R9: When program and supervisor-call pulses arrive in the same cycle, svc_pgm_clash is 1 in the next cycle, the program event is serviced and the call is dropped.
- R10: ack_mck, ack_ext and ack_io each pulse for exactly one cycle, the first cycle of the save step of their own swap; intr_class holds the class from that cycle through the load cycle.
- R11: Program and supervisor-call pulses that arrive while a swap is running are kept and serviced afterwards in R2 order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sw | input | 64 | Current status word |
| mck_req | input | 1 | Machine-check level request |
| pgm_req | input | 1 | Program exception pulse |
| pgm_code | input | PGM_CODE_W | Exception code |
| pgm_ilc | input | 2 | Length code of the failing instruction |
| pgm_imprecise | input | 1 | Exception is imprecise |
| svc_req | input | 1 | Supervisor-call pulse |
| svc_num | input | 8 | Call number |
| svc_ilc | input | 2 | Length code of the call instruction |
| ext_req | input | 1 | External level request |
| ext_src | input | 8 | External source bits |
| io_req | input | 1 | I/O level request |
| io_chan | input | CHAN_W | Requesting channel |
| io_dev | input | DEV_W | Requesting device |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Doubleword byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| psw_load | output | 1 | Load strobe for the new status word |
| psw_new | output | 64 | New status word |
| busy | output | 1 | A swap is running |
| intr_class | output | 3 | Class being serviced, 0 when idle |
| ack_mck | output | 1 | Machine-check request taken |
| ack_ext | output | 1 | External request taken |
| ack_io | output | 1 | I/O request taken |
| svc_pgm_clash | output | 1 | Program and call pulses coincided |

## Verification
Two events can land in the same cycle: a program exception and a supervisor call both arriving, and a fresh pulse arriving while an earlier swap holds the unit. The bench fires both pulses on one clock and expects the clash flag one cycle later, a single program swap to the 28 slot, and then silence. It also raises every source together with one pulse a cycle later, then checks that the five swaps appear in strict priority order with nothing lost.

// File: rtl/intr_swap_pkg.sv
package intr_swap_pkg;

   typedef enum logic [2:0] {
      CLS_NONE = 3'd0,
      CLS_MCK  = 3'd1,
      CLS_PGM  = 3'd2,
      CLS_SVC  = 3'd3,
      CLS_EXT  = 3'd4,
      CLS_IO   = 3'd5
   } cls_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_STORE,
      ST_FETCH,
      ST_LOAD
   } swap_st_e;

   localparam int SW_W      = 64;
   localparam int CODE_W    = 16;
   localparam int CODE_LSB  = 32;
   localparam int ILC_LSB   = 30;
   localparam logic [7:0] LOAD_OFS = 8'h40;

   // save slot of each class in low storage
   function automatic logic [7:0] save_slot(cls_e c);
      logic [7:0] a;
      case (c)
         CLS_MCK: a = 8'h30;
         CLS_PGM: a = 8'h28;
         CLS_SVC: a = 8'h20;
         CLS_EXT: a = 8'h18;
         CLS_IO:  a = 8'h38;
         default: a = 8'h00;
      endcase
      return a;
   endfunction

   function automatic logic [7:0] load_slot(cls_e c);
      return save_slot(c) + LOAD_OFS;
   endfunction

endpackage

// File: rtl/intr_capture.sv
module intr_capture
   import intr_swap_pkg::*;
#(
   parameter int PGM_CODE_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            prog_mask,
   input  logic                  pgm_req,
   input  logic [PGM_CODE_W-1:0] pgm_code,
   input  logic [1:0]            pgm_ilc,
   input  logic                  pgm_imprecise,
   input  logic                  svc_req,
   input  logic [7:0]            svc_num,
   input  logic [1:0]            svc_ilc,
   input  logic                  take_pgm,
   input  logic                  take_svc,
   output logic                  pgm_pend,
   output logic [PGM_CODE_W-1:0] pgm_code_q,
   output logic [1:0]            pgm_ilc_q,
   output logic                  svc_pend,
   output logic [7:0]            svc_num_q,
   output logic [1:0]            svc_ilc_q,
   output logic                  clash
);

   logic pgm_blocked;
   logic pgm_ok;
   logic svc_ok;

   // exceptions that the program mask can suppress
   always_comb begin
      pgm_blocked = 1'b0;
      case (pgm_code)
         PGM_CODE_W'(8):  pgm_blocked = !prog_mask[3];
         PGM_CODE_W'(10): pgm_blocked = !prog_mask[2];
         PGM_CODE_W'(13): pgm_blocked = !prog_mask[1];
         PGM_CODE_W'(14): pgm_blocked = !prog_mask[0];
         default:         pgm_blocked = 1'b0;
      endcase
   end

   assign pgm_ok = pgm_req && !pgm_blocked;
   // a call colliding with a program pulse is dropped
   assign svc_ok = svc_req && !pgm_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pgm_pend   <= 1'b0;
         pgm_code_q <= '0;
         pgm_ilc_q  <= 2'b00;
         svc_pend   <= 1'b0;
         svc_num_q  <= 8'h00;
         svc_ilc_q  <= 2'b00;
         clash      <= 1'b0;
      end else begin
         clash <= pgm_req && svc_req;

         if (pgm_ok && (!pgm_pend || take_pgm)) begin
            pgm_pend   <= 1'b1;
            pgm_code_q <= pgm_code;
            pgm_ilc_q  <= pgm_imprecise ? 2'b00 : pgm_ilc;
         end else if (take_pgm) begin
            pgm_pend <= 1'b0;
         end

         if (svc_ok && (!svc_pend || take_svc)) begin
            svc_pend  <= 1'b1;
            svc_num_q <= svc_num;
            svc_ilc_q <= svc_ilc;
         end else if (take_svc) begin
            svc_pend <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
   import intr_swap_pkg::*;
#(
   parameter int CHAN_W         = 8,
   parameter int DIRECT_CH      = 6,
   parameter bit PGM_BEFORE_SVC = 1'b1
) (
   input  logic [7:0]        sys_mask,
   input  logic              mck_req,
   input  logic              pgm_pend,
   input  logic              svc_pend,
   input  logic              ext_req,
   input  logic              io_req,
   input  logic [CHAN_W-1:0] io_chan,
   output cls_e              pick
);

   logic io_en;
   logic io_ok;
   logic ext_ok;
   logic lvl2_a_req;
   logic lvl2_b_req;
   cls_e lvl2_a_cls;
   cls_e lvl2_b_cls;

   // channels below DIRECT_CH own a mask bit; the rest share one
   always_comb begin
      io_en = sys_mask[7-DIRECT_CH];
      for (int c = 0; c < DIRECT_CH; c++) begin
         if (io_chan == CHAN_W'(c)) io_en = sys_mask[7-c];
      end
   end

   assign io_ok  = io_req && io_en;
   assign ext_ok = ext_req && sys_mask[0];

   // order inside the shared second level
   generate
      if (PGM_BEFORE_SVC) begin : g_pgm_first
         assign lvl2_a_req = pgm_pend;
         assign lvl2_a_cls = CLS_PGM;
         assign lvl2_b_req = svc_pend;
         assign lvl2_b_cls = CLS_SVC;
      end else begin : g_svc_first
         assign lvl2_a_req = svc_pend;
         assign lvl2_a_cls = CLS_SVC;
         assign lvl2_b_req = pgm_pend;
         assign lvl2_b_cls = CLS_PGM;
      end
   endgenerate

   always_comb begin
      if (mck_req)         pick = CLS_MCK;
      else if (lvl2_a_req) pick = lvl2_a_cls;
      else if (lvl2_b_req) pick = lvl2_b_cls;
      else if (ext_ok)     pick = CLS_EXT;
      else if (io_ok)      pick = CLS_IO;
      else                 pick = CLS_NONE;
   end

endmodule

// File: rtl/intr_swap_fsm.sv
module intr_swap_fsm
   import intr_swap_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int CHAN_W     = 8,
   parameter int DEV_W      = 8,
   parameter int PGM_CODE_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  cls_e                  pick,
   input  logic [SW_W-1:0]       cur_sw,
   input  logic [PGM_CODE_W-1:0] pgm_code_q,
   input  logic [1:0]            pgm_ilc_q,
   input  logic [7:0]            svc_num_q,
   input  logic [1:0]            svc_ilc_q,
   input  logic [7:0]            ext_src,
   input  logic [CHAN_W-1:0]     io_chan,
   input  logic [DEV_W-1:0]      io_dev,
   input  logic                  mem_ack,
   input  logic [SW_W-1:0]       mem_rdata,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [SW_W-1:0]       mem_wdata,
   output logic                  psw_load,
   output logic [SW_W-1:0]       psw_new,
   output logic                  busy,
   output logic [2:0]            intr_class,
   output logic                  take_pgm,
   output logic                  take_svc,
   output logic                  ack_mck,
   output logic                  ack_ext,
   output logic                  ack_io
);

   swap_st_e        st;
   cls_e            cls_q;
   logic [SW_W-1:0] hold_q;
   logic [SW_W-1:0] old_word;
   logic            grant;

   assign grant = (st == ST_IDLE) && (pick != CLS_NONE);

   // old status word with code and length folded in
   always_comb begin
      old_word = cur_sw;
      case (pick)
         CLS_PGM: begin
            old_word[CODE_LSB +: CODE_W] = CODE_W'(pgm_code_q);
            old_word[ILC_LSB +: 2]       = pgm_ilc_q;
         end
         CLS_SVC: begin
            old_word[CODE_LSB +: CODE_W] = {8'h00, svc_num_q};
            old_word[ILC_LSB +: 2]       = svc_ilc_q;
         end
         CLS_EXT: old_word[CODE_LSB +: CODE_W] = {8'h00, ext_src};
         CLS_IO:  old_word[CODE_LSB +: CODE_W] = {io_chan, io_dev};
         default: old_word = cur_sw;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cls_q   <= CLS_NONE;
         hold_q  <= '0;
         ack_mck <= 1'b0;
         ack_ext <= 1'b0;
         ack_io  <= 1'b0;
      end else begin
         ack_mck <= 1'b0;
         ack_ext <= 1'b0;
         ack_io  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (grant) begin
                  st      <= ST_STORE;
                  cls_q   <= pick;
                  hold_q  <= old_word;
                  ack_mck <= (pick == CLS_MCK);
                  ack_ext <= (pick == CLS_EXT);
                  ack_io  <= (pick == CLS_IO);
               end
            end
            ST_STORE: begin
               if (mem_ack) st <= ST_FETCH;
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  hold_q <= mem_rdata;
                  st     <= ST_LOAD;
               end
            end
            default: begin
               st    <= ST_IDLE;
               cls_q <= CLS_NONE;
            end
         endcase
      end
   end

   assign mem_req    = (st == ST_STORE) || (st == ST_FETCH);
   assign mem_we     = (st == ST_STORE);
   assign mem_addr   = ADDR_W'((st == ST_FETCH) ? load_slot(cls_q) : save_slot(cls_q));
   assign mem_wdata  = hold_q;
   assign psw_load   = (st == ST_LOAD);
   assign psw_new    = hold_q;
   assign busy       = (st != ST_IDLE);
   assign intr_class = cls_q;
   assign take_pgm   = grant && (pick == CLS_PGM);
   assign take_svc   = grant && (pick == CLS_SVC);

endmodule

// File: rtl/intr_swap_unit.sv
module intr_swap_unit
   import intr_swap_pkg::*;
#(
   parameter int ADDR_W         = 24,
   parameter int CHAN_W         = 8,
   parameter int DEV_W          = 8,
   parameter int PGM_CODE_W     = 6,
   parameter int DIRECT_CH      = 6,
   parameter bit PGM_BEFORE_SVC = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [63:0]           cur_sw,
   input  logic                  mck_req,
   input  logic                  pgm_req,
   input  logic [PGM_CODE_W-1:0] pgm_code,
   input  logic [1:0]            pgm_ilc,
   input  logic                  pgm_imprecise,
   input  logic                  svc_req,
   input  logic [7:0]            svc_num,
   input  logic [1:0]            svc_ilc,
   input  logic                  ext_req,
   input  logic [7:0]            ext_src,
   input  logic                  io_req,
   input  logic [CHAN_W-1:0]     io_chan,
   input  logic [DEV_W-1:0]      io_dev,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [63:0]           mem_wdata,
   input  logic                  mem_ack,
   input  logic [63:0]           mem_rdata,
   output logic                  psw_load,
   output logic [63:0]           psw_new,
   output logic                  busy,
   output logic [2:0]            intr_class,
   output logic                  ack_mck,
   output logic                  ack_ext,
   output logic                  ack_io,
   output logic                  svc_pgm_clash
);

   localparam int SYS_MSB = SW_W - 1;
   localparam int SYS_LSB = SW_W - 8;

   generate
      if (CHAN_W + DEV_W != CODE_W) begin : g_bad_code
         $error("channel and device widths must fill the code field");
      end
      if (DIRECT_CH < 1 || DIRECT_CH > 7) begin : g_bad_direct
         $error("DIRECT_CH must lie in 1..7");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must reach the low-storage slots");
      end
      if (PGM_CODE_W < 4 || PGM_CODE_W > CODE_W) begin : g_bad_pgm
         $error("PGM_CODE_W out of range");
      end
   endgenerate

   logic                  pgm_pend;
   logic                  svc_pend;
   logic [PGM_CODE_W-1:0] pgm_code_q;
   logic [1:0]            pgm_ilc_q;
   logic [7:0]            svc_num_q;
   logic [1:0]            svc_ilc_q;
   logic                  take_pgm;
   logic                  take_svc;
   cls_e                  pick;

   intr_capture #(
      .PGM_CODE_W (PGM_CODE_W)
   ) u_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .prog_mask     (cur_sw[27:24]),
      .pgm_req       (pgm_req),
      .pgm_code      (pgm_code),
      .pgm_ilc       (pgm_ilc),
      .pgm_imprecise (pgm_imprecise),
      .svc_req       (svc_req),
      .svc_num       (svc_num),
      .svc_ilc       (svc_ilc),
      .take_pgm      (take_pgm),
      .take_svc      (take_svc),
      .pgm_pend      (pgm_pend),
      .pgm_code_q    (pgm_code_q),
      .pgm_ilc_q     (pgm_ilc_q),
      .svc_pend      (svc_pend),
      .svc_num_q     (svc_num_q),
      .svc_ilc_q     (svc_ilc_q),
      .clash         (svc_pgm_clash)
   );

   intr_arbiter #(
      .CHAN_W         (CHAN_W),
      .DIRECT_CH      (DIRECT_CH),
      .PGM_BEFORE_SVC (PGM_BEFORE_SVC)
   ) u_arbiter (
      .sys_mask (cur_sw[SYS_MSB:SYS_LSB]),
      .mck_req  (mck_req),
      .pgm_pend (pgm_pend),
      .svc_pend (svc_pend),
      .ext_req  (ext_req),
      .io_req   (io_req),
      .io_chan  (io_chan),
      .pick     (pick)
   );

   intr_swap_fsm #(
      .ADDR_W     (ADDR_W),
      .CHAN_W     (CHAN_W),
      .DEV_W      (DEV_W),
      .PGM_CODE_W (PGM_CODE_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pick       (pick),
      .cur_sw     (cur_sw),
      .pgm_code_q (pgm_code_q),
      .pgm_ilc_q  (pgm_ilc_q),
      .svc_num_q  (svc_num_q),
      .svc_ilc_q  (svc_ilc_q),
      .ext_src    (ext_src),
      .io_chan    (io_chan),
      .io_dev     (io_dev),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .psw_load   (psw_load),
      .psw_new    (psw_new),
      .busy       (busy),
      .intr_class (intr_class),
      .take_pgm   (take_pgm),
      .take_svc   (take_svc),
      .ack_mck    (ack_mck),
      .ack_ext    (ack_ext),
      .ack_io     (ack_io)
   );

endmodule

// File: rtl/intr_swap_chk.sv
module intr_swap_chk
   import intr_swap_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [63:0]       cur_sw,
   input logic              pgm_req,
   input logic              svc_req,
   input logic              io_req,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              psw_load,
   input logic              busy,
   input logic [2:0]        intr_class,
   input logic              ack_mck,
   input logic              ack_ext,
   input logic              ack_io,
   input logic              svc_pgm_clash
);

   assert_save_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr == ADDR_W'(save_slot(cls_e'(intr_class)))));

   assert_load_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr == ADDR_W'(load_slot(cls_e'(intr_class)))));

   assert_store_then_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   assert_fetch_then_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> psw_load);

   assert_load_ends_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      psw_load |=> !busy);

   assert_ext_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ext |-> $past(cur_sw[56]));

   assert_io_was_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_io |-> $past(io_req));

   assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack_mck, ack_ext, ack_io}));

   assert_ack_in_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mck || ack_ext || ack_io) |-> (mem_req && mem_we));

   assert_clash_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      svc_pgm_clash |-> ($past(pgm_req) && $past(svc_req)));

endmodule

bind intr_swap_unit intr_swap_chk #(
   .ADDR_W (ADDR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cur_sw        (cur_sw),
   .pgm_req       (pgm_req),
   .svc_req       (svc_req),
   .io_req        (io_req),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_ack       (mem_ack),
   .mem_addr      (mem_addr),
   .psw_load      (psw_load),
   .busy          (busy),
   .intr_class    (intr_class),
   .ack_mck       (ack_mck),
   .ack_ext       (ack_ext),
   .ack_io        (ack_io),
   .svc_pgm_clash (svc_pgm_clash)
);

// File: tb/intr_swap_unit_tb_top.sv
module intr_swap_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cur_sw;
   logic        mck_req = 1'b0;
   logic        pgm_req = 1'b0;
   logic [5:0]  pgm_code = '0;
   logic [1:0]  pgm_ilc = '0;
   logic        pgm_imprecise = 1'b0;
   logic        svc_req = 1'b0;
   logic [7:0]  svc_num = '0;
   logic [1:0]  svc_ilc = '0;
   logic        ext_req = 1'b0;
   logic [7:0]  ext_src = '0;
   logic        io_req = 1'b0;
   logic [7:0]  io_chan = '0;
   logic [7:0]  io_dev = '0;
   logic        mem_req, mem_we, mem_ack;
   logic [23:0] mem_addr;
   logic [63:0] mem_wdata, mem_rdata;
   logic        psw_load, busy;
   logic [63:0] psw_new;
   logic [2:0]  intr_class;
   logic        ack_mck, ack_ext, ack_io, svc_pgm_clash;

   logic        set_en = 1'b0;
   logic [63:0] set_val = '0;
   logic [63:0] mem [0:15];
   logic [23:0] wr_addr_log, rd_addr_log;
   logic [63:0] wr_data_log;
   int          n_load;
   int          load_log [0:63];
   int          total = 0;
   int          bad = 0;
   int          cyc = 0;

   always #2 clk = ~clk;

   intr_swap_unit dut_i (
      .clk (clk), .rst_n (rst_n), .cur_sw (cur_sw),
      .mck_req (mck_req), .pgm_req (pgm_req), .pgm_code (pgm_code),
      .pgm_ilc (pgm_ilc), .pgm_imprecise (pgm_imprecise),
      .svc_req (svc_req), .svc_num (svc_num), .svc_ilc (svc_ilc),
      .ext_req (ext_req), .ext_src (ext_src),
      .io_req (io_req), .io_chan (io_chan), .io_dev (io_dev),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata),
      .psw_load (psw_load), .psw_new (psw_new), .busy (busy),
      .intr_class (intr_class), .ack_mck (ack_mck), .ack_ext (ack_ext),
      .ack_io (ack_io), .svc_pgm_clash (svc_pgm_clash)
   );

   function automatic logic [63:0] new_word(input int idx);
      return 64'hFF00_0000_0F00_0000 | 64'(idx);
   endfunction

   function automatic logic [63:0] mk(input logic [7:0] sm, input logic [3:0] pm);
      logic [63:0] w;
      w = {sm, 56'h12_3456_4ABC_DEF0};
      w[27:24] = pm;
      return w;
   endfunction

   function automatic logic [63:0] fold(input logic [63:0] w, input logic [15:0] code,
                                        input logic [1:0] ilc);
      logic [63:0] r;
      r = w;
      r[47:32] = code;
      r[31:30] = ilc;
      return r;
   endfunction

   assign mem_rdata = mem[mem_addr[6:3]];

   // memory and sequencer models
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         n_load  <= 0;
         cur_sw  <= '0;
         wr_addr_log <= '0;
         rd_addr_log <= '0;
         wr_data_log <= '0;
         for (int i = 0; i < 16; i++) mem[i] <= new_word(i);
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && mem_ack) begin
            if (mem_we) begin
               mem[mem_addr[6:3]] <= mem_wdata;
               wr_addr_log <= mem_addr;
               wr_data_log <= mem_wdata;
            end else begin
               rd_addr_log <= mem_addr;
            end
         end
         if (psw_load) begin
            cur_sw <= psw_new;
            load_log[n_load] <= int'(intr_class);
            n_load <= n_load + 1;
         end else if (set_en) begin
            cur_sw <= set_val;
         end
      end
   end

   // level sources withdraw once acknowledged
   always @(negedge clk) begin
      if (ack_io)  io_req  = 1'b0;
      if (ack_ext) ext_req = 1'b0;
      if (ack_mck) mck_req = 1'b0;
   end

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
         report();
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic set_sw(input logic [63:0] v);
      @(negedge clk);
      set_val = v;
      set_en  = 1'b1;
      @(negedge clk);
      set_en  = 1'b0;
   endtask

   task automatic pulse_pgm(input logic [5:0] code, input logic [1:0] ilc, input bit imp);
      @(negedge clk);
      pgm_req = 1'b1; pgm_code = code; pgm_ilc = ilc; pgm_imprecise = imp;
      @(negedge clk);
      pgm_req = 1'b0; pgm_imprecise = 1'b0;
   endtask

   task automatic expect_quiet(input string tag, input int n);
      bit moved = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mem_req || ack_io || ack_ext || ack_mck) moved = 1;
      end
      chk(!moved, tag, 64'(moved), 64'd0);
   endtask

   task automatic expect_swap(input string tag, input int cls, input logic [7:0] slot,
                              input logic [63:0] word);
      bit seen = 0;
      int got_cls = 0;
      logic [63:0] got_new = '0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (psw_load) begin
            seen = 1; got_cls = int'(intr_class); got_new = psw_new;
            break;
         end
      end
      chk(seen, {tag, " load strobe"}, 64'(seen), 64'd1);
      chk(got_cls == cls, {tag, " class"}, 64'(got_cls), 64'(cls));
      chk(wr_addr_log == 24'(slot), {tag, " save slot"}, 64'(wr_addr_log), 64'(slot));
      chk(rd_addr_log == 24'(slot + 8'h40), {tag, " load slot"}, 64'(rd_addr_log),
          64'(slot + 8'h40));
      chk(wr_data_log == word, {tag, " saved word"}, wr_data_log, word);
      chk(got_new == new_word(int'(slot[6:3]) + 8), {tag, " new word"}, got_new,
          new_word(int'(slot[6:3]) + 8));
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!busy && !mem_req && !psw_load && !svc_pgm_clash, "R1 idle flags",
          64'({busy, mem_req, psw_load, svc_pgm_clash}), 64'd0);
      chk(intr_class == 3'd0 && !ack_io && !ack_ext && !ack_mck, "R1 class/acks",
          64'({intr_class, ack_io, ack_ext, ack_mck}), 64'd0);
   endtask

   task automatic t_io_direct();
      logic [63:0] w = mk(8'h10, 4'h0);
      set_sw(w);
      @(negedge clk);
      io_req = 1'b1; io_chan = 8'h03; io_dev = 8'h45;
      @(negedge clk);
      chk(ack_io && intr_class == 3'd5, "R10 ack_io timing", 64'({ack_io, intr_class}),
          64'({1'b1, 3'd5}));
      expect_swap("R7 R3 io ch3", 5, 8'h38, fold(w, 16'h0345, w[31:30]));
   endtask

   task automatic t_io_masked();
      logic [63:0] w = mk(8'h10, 4'h0);
      set_sw(mk(8'hEF, 4'h0));
      @(negedge clk);
      io_req = 1'b1; io_chan = 8'h03; io_dev = 8'h11;
      expect_quiet("R5 io ch3 masked", 12);
      set_sw(w);
      expect_swap("R5 io ch3 enabled later", 5, 8'h38, fold(w, 16'h0311, w[31:30]));
   endtask

   task automatic t_io_high();
      logic [63:0] w = mk(8'h02, 4'h0);
      set_sw(mk(8'hFD, 4'h0));
      @(negedge clk);
      io_req = 1'b1; io_chan = 8'h09; io_dev = 8'h7E;
      expect_quiet("R5 ch9 needs bit 6", 12);
      set_sw(w);
      expect_swap("R5 ch9 via bit 6", 5, 8'h38, fold(w, 16'h097E, w[31:30]));
   endtask

   task automatic t_ext();
      logic [63:0] w = mk(8'h01, 4'h0);
      set_sw(mk(8'hFE, 4'h0));
      @(negedge clk);
      ext_req = 1'b1; ext_src = 8'h81;
      expect_quiet("R5 external masked", 12);
      set_sw(w);
      expect_swap("R7 external code", 4, 8'h18, fold(w, 16'h0081, w[31:30]));
   endtask

   task automatic t_pgm_mask();
      logic [63:0] w;
      set_sw(mk(8'h00, 4'h0));
      pulse_pgm(6'd8, 2'd2, 1'b0);
      expect_quiet("R6 code 8 masked", 12);
      set_sw(mk(8'h00, 4'hE));
      pulse_pgm(6'd14, 2'd2, 1'b0);
      expect_quiet("R6 code 14 masked", 12);
      w = mk(8'h00, 4'h8);
      set_sw(w);
      pulse_pgm(6'd8, 2'd2, 1'b0);
      expect_swap("R6 code 8 enabled", 2, 8'h28, fold(w, 16'h0008, 2'd2));
      w = mk(8'h00, 4'h0);
      set_sw(w);
      pulse_pgm(6'd6, 2'd3, 1'b0);
      expect_swap("R6 code 6 unmaskable", 2, 8'h28, fold(w, 16'h0006, 2'd3));
   endtask

   task automatic t_imprecise();
      logic [63:0] w = mk(8'h00, 4'h0);
      set_sw(w);
      pulse_pgm(6'd5, 2'd3, 1'b1);
      expect_swap("R8 imprecise ilc", 2, 8'h28, fold(w, 16'h0005, 2'd0));
   endtask

   task automatic t_svc();
      logic [63:0] w = mk(8'h00, 4'h0);
      set_sw(w);
      @(negedge clk);
      svc_req = 1'b1; svc_num = 8'h2A; svc_ilc = 2'd1;
      @(negedge clk);
      svc_req = 1'b0;
      expect_swap("R7 R3 supervisor call", 3, 8'h20, fold(w, 16'h002A, 2'd1));
   endtask

   task automatic t_mck();
      logic [63:0] w = mk(8'h00, 4'h3);
      set_sw(w);
      @(negedge clk);
      mck_req = 1'b1;
      expect_swap("R7 R3 machine check", 1, 8'h30, w);
   endtask

   task automatic t_clash();
      logic [63:0] w = mk(8'h00, 4'h0);
      set_sw(w);
      @(negedge clk);
      pgm_req = 1'b1; pgm_code = 6'd4; pgm_ilc = 2'd2;
      svc_req = 1'b1; svc_num = 8'h33; svc_ilc = 2'd1;
      @(negedge clk);
      pgm_req = 1'b0; svc_req = 1'b0;
      chk(svc_pgm_clash, "R9 clash flag", 64'(svc_pgm_clash), 64'd1);
      expect_swap("R9 program wins", 2, 8'h28, fold(w, 16'h0004, 2'd2));
      expect_quiet("R9 call dropped", 12);
   endtask

   task automatic t_priority();
      int base;
      int expv [0:4] = '{1, 2, 3, 4, 5};
      set_sw(mk(8'hFF, 4'hF));
      base = n_load;
      @(negedge clk);
      mck_req = 1'b1; ext_req = 1'b1; ext_src = 8'h40;
      io_req = 1'b1; io_chan = 8'h01; io_dev = 8'h22;
      pgm_req = 1'b1; pgm_code = 6'd6; pgm_ilc = 2'd1;
      @(negedge clk);
      pgm_req = 1'b0;
      svc_req = 1'b1; svc_num = 8'h05; svc_ilc = 2'd1;
      @(negedge clk);
      svc_req = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (n_load >= base + 5) break;
         @(negedge clk);
      end
      chk(n_load == base + 5, "R11 all five serviced", 64'(n_load - base), 64'd5);
      for (int k = 0; k < 5; k++)
         chk(load_log[base + k] == expv[k], "R2 service order",
             64'(load_log[base + k]), 64'(expv[k]));
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_io_direct();
      t_io_masked();
      t_io_high();
      t_ext();
      t_pgm_mask();
      t_imprecise();
      t_svc();
      t_mck();
      t_clash();
      t_priority();
      repeat (4) @(negedge clk);
      report();
   end

endmodule